// File: doc/BRIEF.md
# Small-page NAND command and address sequencer

This block turns a host request into the command and address phases on the 8-bit bus of a small-page NAND flash device with 256- or 512-byte pages. A request names one of three actions: a command, a select or a deselect. A command request carries a command byte, an optional column, an optional page address, the page-size mode and the two device-size bits that decide whether a third page byte is needed. The block drives the chip-enable, command-latch and address-latch lines, puts each byte on the bus with its own write strobe, and then turns the bus around to input. It waits a settling time before it pulses done.

A program data-input request (0x80) needs a pointer command first, so that the device's internal column pointer lands in the right area. The block picks that command from the page size and the column, and rebases the column it sends to match. A select request drives chip enable low and issues a reset command with no address, then waits a shorter delay. A deselect request drives chip enable high. Data transfer, error correction and the ready/busy pin belong to other blocks.

Top module: `nand_cmd_seq`

## Requirements
- R1: Every command byte is strobed with CLE high and ALE low. Every address byte is strobed with ALE high and CLE low. All command bytes of a request come before its address bytes.
- R2: For a request with command 0x80 in 512-byte mode (`req_large`=1), the bytes sent depend on the column. A valid column of 512 or more sends 0x50 then 0x80, and the column byte becomes column−512. A valid column from 256 to 511 sends 0x01 then 0x80, and the column byte becomes column−256. Any other case, including no column, sends 0x00 then 0x80.
- R3: For a request with command 0x80 in 256-byte mode (`req_large`=0), a valid column of 256 or more sends 0xFF, 0x50 and 0x80 in that order, and the column byte becomes column−256. Any other case sends 0x00 then 0x80.
- R4: Any other command code is sent as one byte, unchanged. The column byte (the low 8 bits of the possibly rebased column) is sent only when `req_col_vld`=1, and it is the first address byte.
- R5: When `req_page_vld`=1, the page address follows the column as bits 7:0 and then bits 15:8. Bits 23:16 are added as a third byte when either bit of `req_size_hi` (device-size bits 27:26) is set.
- R6: Each byte is driven with `nand_dq_oe`=1. `nand_we_n` stays high for at least SETUP_CYC cycles, then goes low for exactly PULSE_CYC cycles, then rises. The data, CLE and ALE do not change from the falling edge of the strobe through the cycle in which it rises.
- R7: After the last byte of a command request, CLE, ALE and `nand_dq_oe` are low, and `done` is high for one cycle exactly SETTLE_CYC+1 cycles after the cycle in which the last strobe rose.
- R8: A select request (`req_kind`=1) drives `nand_ce_n` low, sends the single command byte 0xFF with no address, and pulses `done` SELECT_CYC+1 cycles after that strobe rose.
- R9: A deselect request (`req_kind`=2) drives `nand_ce_n` high, produces no strobe, and pulses `done` in the cycle after it is accepted.
- R10: A request made while `busy`=1 has no effect on chip enable or on the bytes of the sequence in progress. A request with `req_kind`=3 is ignored and produces neither a strobe nor `done`.
- R11: After reset, `nand_ce_n`=1, `nand_we_n`=1, CLE=0, ALE=0, `nand_dq_oe`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 2 | 0 command, 1 select, 2 deselect, 3 ignored |
| req_cmd | input | 8 | Command code |
| req_col_vld | input | 1 | Column present |
| req_col | input | 10 | Column within page plus spare area |
| req_page_vld | input | 1 | Page address present |
| req_page | input | 24 | Page address |
| req_large | input | 1 | 1 for 512-byte pages, 0 for 256-byte pages |
| req_size_hi | input | 2 | Device-size bits 27:26 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq_out | output | 8 | Bus output byte |
| nand_dq_oe | output | 1 | Bus output enable |

## Verification
The hardest situation to reach is a second request arriving in the middle of a sequence. It must leave both chip enable and the byte stream untouched. The bench first selects the device, then starts an addressed command and, while the write strobe is mid-byte, offers a deselect for one cycle. It then checks that chip enable is still low and that the captured bytes match the original request. The pointer-command choice is swept over the column boundaries 255/256 and 511/512 in both page modes, with the column present and absent. Every strobed byte is rebuilt from its rising edge and compared with a list that the bench derives from the rules.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 2,
  parameter int SETTLE_CYC = 5000,
  parameter int SELECT_CYC = 1250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [7:0]  req_cmd,
  input  logic        req_col_vld,
  input  logic [9:0]  req_col,
  input  logic        req_page_vld,
  input  logic [23:0] req_page,
  input  logic        req_large,
  input  logic [1:0]  req_size_hi,
  output logic        busy,
  output logic        done,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe
);
  localparam int BYTE_CYC = SETUP_CYC + PULSE_CYC + 1;
  localparam int PW       = $clog2(BYTE_CYC + 1);
  localparam int WMAX     = (SETTLE_CYC > SELECT_CYC) ? SETTLE_CYC : SELECT_CYC;
  localparam int WW       = $clog2(WMAX + 1);

  localparam logic [7:0] OP_READ0 = 8'h00;
  localparam logic [7:0] OP_READ1 = 8'h01;
  localparam logic [7:0] OP_OOB   = 8'h50;
  localparam logic [7:0] OP_SEQIN = 8'h80;
  localparam logic [7:0] OP_RESET = 8'hFF;

  localparam logic [1:0] K_CMD = 2'd0;
  localparam logic [1:0] K_SEL = 2'd1;
  localparam logic [1:0] K_DES = 2'd2;

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_BYTE = 2'd1;
  localparam logic [1:0] ST_WAIT = 2'd2;

  logic [1:0]    state;
  logic [PW-1:0] ph;
  logic [2:0]    idx;
  logic [1:0]    n_cmd;
  logic [2:0]    n_addr;
  logic [7:0]    cmdq  [3];
  logic [7:0]    addrq [4];
  logic [WW-1:0] wcnt, wlim;
  logic          ce_n_q, done_q;

  logic [7:0] b_c [3];
  logic [7:0] b_a [4];
  logic [1:0] b_nc;
  logic [2:0] b_na;
  logic [9:0] col_eff;

  always_comb begin
    b_c[0]  = req_cmd;
    b_c[1]  = 8'h00;
    b_c[2]  = 8'h00;
    b_nc    = 2'd1;
    col_eff = req_col;
    for (int i = 0; i < 4; i++) b_a[i] = 8'h00;
    b_na    = 3'd0;
    if (req_kind == K_SEL) begin
      b_c[0] = OP_RESET;
    end else if (req_cmd == OP_SEQIN) begin
      b_nc = 2'd2;
      if (req_col_vld && req_col >= 10'd256) begin
        if (!req_large) begin
          b_c[0]  = OP_RESET;
          b_c[1]  = OP_OOB;
          b_c[2]  = OP_SEQIN;
          b_nc    = 2'd3;
          col_eff = req_col - 10'd256;
        end else if (req_col >= 10'd512) begin
          b_c[0]  = OP_OOB;
          b_c[1]  = OP_SEQIN;
          col_eff = req_col - 10'd512;
        end else begin
          b_c[0]  = OP_READ1;
          b_c[1]  = OP_SEQIN;
          col_eff = req_col - 10'd256;
        end
      end else begin
        b_c[0] = OP_READ0;
        b_c[1] = OP_SEQIN;
      end
    end
    if (req_kind == K_CMD) begin
      if (req_col_vld) begin
        b_a[b_na[1:0]] = col_eff[7:0];
        b_na = b_na + 3'd1;
      end
      if (req_page_vld) begin
        b_a[b_na[1:0]] = req_page[7:0];
        b_na = b_na + 3'd1;
        b_a[b_na[1:0]] = req_page[15:8];
        b_na = b_na + 3'd1;
        if (|req_size_hi) begin
          b_a[b_na[1:0]] = req_page[23:16];
          b_na = b_na + 3'd1;
        end
      end
    end
  end

  wire       accept   = req_valid && state == ST_IDLE;
  wire [2:0] n_total  = {1'b0, n_cmd} + n_addr;
  wire       cur_cmd  = idx < {1'b0, n_cmd};
  wire [2:0] aidx     = idx - {1'b0, n_cmd};
  wire [7:0] cur_byte = cur_cmd ? cmdq[idx[1:0]] : addrq[aidx[1:0]];
  wire       ph_end   = ph == PW'(BYTE_CYC - 1);
  wire       last     = idx == n_total - 3'd1;
  wire       in_byte  = state == ST_BYTE;

  assign busy        = state != ST_IDLE;
  assign done        = done_q;
  assign nand_ce_n   = ce_n_q;
  assign nand_cle    = in_byte && cur_cmd;
  assign nand_ale    = in_byte && !cur_cmd;
  assign nand_we_n   = !(in_byte && ph >= PW'(SETUP_CYC) && ph < PW'(SETUP_CYC + PULSE_CYC));
  assign nand_dq_oe  = in_byte;
  assign nand_dq_out = in_byte ? cur_byte : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ph     <= '0;
      idx    <= '0;
      n_cmd  <= '0;
      n_addr <= '0;
      wcnt   <= '0;
      wlim   <= '0;
      ce_n_q <= 1'b1;
      done_q <= 1'b0;
      for (int i = 0; i < 3; i++) cmdq[i] <= 8'h00;
      for (int i = 0; i < 4; i++) addrq[i] <= 8'h00;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept && req_kind == K_DES) begin
            ce_n_q <= 1'b1;
            done_q <= 1'b1;
          end else if (accept && (req_kind == K_CMD || req_kind == K_SEL)) begin
            for (int i = 0; i < 3; i++) cmdq[i] <= b_c[i];
            for (int i = 0; i < 4; i++) addrq[i] <= b_a[i];
            n_cmd  <= b_nc;
            n_addr <= b_na;
            idx    <= '0;
            ph     <= '0;
            wlim   <= (req_kind == K_SEL) ? WW'(SELECT_CYC) : WW'(SETTLE_CYC);
            if (req_kind == K_SEL) ce_n_q <= 1'b0;
            state  <= ST_BYTE;
          end
        end
        ST_BYTE: begin
          if (ph_end) begin
            ph <= '0;
            if (last) begin
              state <= ST_WAIT;
              wcnt  <= '0;
            end else begin
              idx <= idx + 3'd1;
            end
          end else begin
            ph <= ph + PW'(1);
          end
        end
        ST_WAIT: begin
          if (wcnt == wlim - WW'(1)) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R1
  AST_STROBE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out)); // R6
  AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> nand_dq_oe && $stable(nand_dq_out) && $stable(nand_cle)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> nand_we_n && !nand_cle && !nand_ale && !nand_dq_oe); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_SELECT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == K_SEL) |=> !nand_ce_n && busy); // R8
  AST_DESELECT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == K_DES) |=> nand_ce_n && done); // R9
  AST_BUSY_CE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nand_ce_n)); // R10
endmodule

// File: tb/nand_cmd_seq_tb.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb;
  localparam int SU = 2, PU = 3, ST = 7, SE = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_col_vld = 0, req_page_vld = 0, req_large = 0;
  logic [1:0] req_kind = 0, req_size_hi = 0;
  logic [7:0] req_cmd = 0;
  logic [9:0] req_col = 0;
  logic [23:0] req_page = 0;
  logic busy, done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_dq_oe;
  logic [7:0] nand_dq_out;

  nand_cmd_seq #(.SETUP_CYC(SU), .PULSE_CYC(PU), .SETTLE_CYC(ST), .SELECT_CYC(SE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_cmd(req_cmd),
    .req_col_vld(req_col_vld), .req_col(req_col), .req_page_vld(req_page_vld),
    .req_page(req_page), .req_large(req_large), .req_size_hi(req_size_hi),
    .busy(busy), .done(done), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int ncap = 0, mon_err = 0, hi_run = 0, low_run = 0, last_rise = 0, done_cyc = 0;
  bit done_seen = 0, prev_we = 1, fall_cle = 0, fall_ale = 0;
  logic [7:0] fall_dq;
  logic [7:0] cap_b [16];
  bit cap_c [16];
  logic [7:0] exp_b [8];
  bit exp_c [8];
  int exp_n;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done) begin done_seen = 1; done_cyc = cyc; end
      if (nand_dq_oe && nand_we_n) hi_run++;
      else if (!nand_dq_oe) hi_run = 0;
      if (prev_we && !nand_we_n) begin
        if (hi_run < SU) mon_err++;
        hi_run = 0; low_run = 0;
        fall_dq = nand_dq_out; fall_cle = nand_cle; fall_ale = nand_ale;
      end
      if (!nand_we_n) low_run++;
      if (!prev_we && nand_we_n) begin
        if (low_run != PU || nand_dq_out != fall_dq || nand_cle != fall_cle ||
            nand_ale != fall_ale || !nand_dq_oe || nand_cle == nand_ale) mon_err++;
        if (ncap < 16) begin cap_b[ncap] = nand_dq_out; cap_c[ncap] = nand_cle; end
        ncap++;
        last_rise = cyc;
      end
      prev_we = nand_we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build_exp(input logic [1:0] kind, input logic [7:0] cmd, input bit cv,
                           input int col, input bit pv, input int page, input bit lg,
                           input logic [1:0] sz);
    int c = col;
    exp_n = 0;
    if (kind == 1) begin exp_b[0] = 8'hFF; exp_c[0] = 1; exp_n = 1; return; end
    if (cmd == 8'h80) begin
      if (cv && col >= 256 && !lg) begin
        exp_b[0] = 8'hFF; exp_b[1] = 8'h50; exp_b[2] = 8'h80; exp_n = 3; c = col - 256;
      end else if (cv && col >= 512) begin
        exp_b[0] = 8'h50; exp_b[1] = 8'h80; exp_n = 2; c = col - 512;
      end else if (cv && col >= 256) begin
        exp_b[0] = 8'h01; exp_b[1] = 8'h80; exp_n = 2; c = col - 256;
      end else begin
        exp_b[0] = 8'h00; exp_b[1] = 8'h80; exp_n = 2;
      end
    end else begin
      exp_b[0] = cmd; exp_n = 1;
    end
    for (int i = 0; i < exp_n; i++) exp_c[i] = 1;
    if (cv) begin exp_b[exp_n] = c % 256; exp_c[exp_n] = 0; exp_n++; end
    if (pv) begin
      exp_b[exp_n] = page % 256; exp_c[exp_n] = 0; exp_n++;
      exp_b[exp_n] = (page / 256) % 256; exp_c[exp_n] = 0; exp_n++;
      if (sz != 0) begin exp_b[exp_n] = (page / 65536) % 256; exp_c[exp_n] = 0; exp_n++; end
    end
  endtask

  task automatic start_req(input logic [1:0] kind, input logic [7:0] cmd, input bit cv,
                           input int col, input bit pv, input int page, input bit lg,
                           input logic [1:0] sz);
    ncap = 0; mon_err = 0; done_seen = 0;
    req_kind = kind; req_cmd = cmd; req_col_vld = cv; req_col = col[9:0];
    req_page_vld = pv; req_page = page[23:0]; req_large = lg; req_size_hi = sz;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 500 && !done_seen; i++) @(negedge clk);
  endtask

  task automatic check_seq(input string req, input int wait_cyc);
    bit ok = (ncap == exp_n) && done_seen;
    int bad = -1;
    for (int i = 0; i < exp_n && i < ncap; i++)
      if (cap_b[i] !== exp_b[i] || cap_c[i] != exp_c[i]) begin ok = 0; if (bad < 0) bad = i; end
    if (bad >= 0) chk(0, req, cap_b[bad], exp_b[bad]);
    else chk(ok, req, ncap, exp_n);
    chk(mon_err == 0, "R6 strobe timing", mon_err, 0);
    chk(done_cyc - last_rise == wait_cyc + 1, (wait_cyc == SE) ? "R8 select wait" : "R7 settle",
        done_cyc - last_rise, wait_cyc + 1);
    chk(!nand_cle && !nand_ale && !nand_dq_oe && !busy, "R7 bus released",
        {nand_cle, nand_ale, nand_dq_oe, busy}, 0);
  endtask

  task automatic run_cmd(input string req, input logic [7:0] cmd, input bit cv, input int col,
                         input bit pv, input int page, input bit lg, input logic [1:0] sz);
    build_exp(0, cmd, cv, col, pv, page, lg, sz);
    start_req(0, cmd, cv, col, pv, page, lg, sz);
    wait_done();
    check_seq(req, ST);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cols [8] = '{0, 17, 255, 256, 263, 300, 511, 527};
    logic [7:0] cmds [6] = '{8'h00, 8'h01, 8'h50, 8'h70, 8'h60, 8'hD0};
    repeat (3) @(negedge clk);
    chk(nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !nand_dq_oe && !busy && !done,
        "R11 reset", {nand_ce_n, nand_we_n, nand_cle, nand_ale, nand_dq_oe, busy, done}, 7'b1100000);
    rst_n = 1;
    @(negedge clk);

    build_exp(1, 0, 0, 0, 0, 0, 0, 0);
    start_req(1, 8'h00, 0, 0, 0, 0, 0, 0);
    chk(!nand_ce_n && busy, "R8 select ce", nand_ce_n, 0);
    wait_done();
    check_seq("R8 select reset byte", SE);

    for (int lg = 0; lg < 2; lg++)
      for (int ci = 0; ci < 8; ci++)
        for (int cv = 0; cv < 2; cv++)
          run_cmd(lg ? "R2 512 seqin" : "R3 256 seqin", 8'h80, cv[0], cols[ci], 1,
                  ci * 4099 + lg * 70001, lg[0], 2'(ci));

    for (int k = 0; k < 6; k++)
      for (int m = 0; m < 4; m++)
        run_cmd((m[1]) ? "R5 page bytes" : "R4 column byte", cmds[k], m[0], 100 + k * 50, m[1],
                24'hA5B6C7 + k * 131 + m, k[0], 2'(m + k));

    run_cmd("R1 no address", 8'h70, 0, 0, 0, 0, 1, 0);
    run_cmd("R5 third byte bit27", 8'h00, 1, 5, 1, 24'h123456, 1, 2'b10);
    run_cmd("R5 third byte bit26", 8'h00, 1, 5, 1, 24'h654321, 1, 2'b01);

    build_exp(0, 8'h00, 1, 9, 1, 24'h0A0B0C, 1, 0);
    start_req(0, 8'h00, 1, 9, 1, 24'h0A0B0C, 1, 0);
    repeat (4) @(negedge clk);
    req_kind = 2; req_cmd = 8'h80; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait_done();
    check_seq("R10 busy request ignored", ST);
    chk(!nand_ce_n, "R10 ce held", nand_ce_n, 0);

    ncap = 0; done_seen = 0;
    req_kind = 3; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (8) @(negedge clk);
    chk(!done_seen && ncap == 0 && !busy && !nand_ce_n, "R10 kind3 ignored", ncap, 0);

    start_req(2, 8'h00, 0, 0, 0, 0, 0, 0);
    chk(done && nand_ce_n && !busy, "R9 deselect", {done, nand_ce_n, busy}, 3'b110);
    repeat (3) @(negedge clk);
    chk(ncap == 0 && nand_ce_n, "R9 no strobe", ncap, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule